// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block is the home-node side of a distributed shared memory system. For each line it keeps a coherence state, a dirty flag, a small set of hardware pointers naming the nodes that hold a copy, an overflow flag and a value register. Requests arrive one at a time on a valid/ready port. Each request carries an opcode, the requesting node, the line index and, for write-backs, the data. The controller updates the directory entry in the cycle it accepts the request. It then sends the resulting coherence messages one per handshake on a valid/ready message port.

Only a few sharers fit in hardware. When one more distinct sharer arrives and every pointer is taken, the controller sets the line's overflow flag and pulses a trap output. Software can then record the extra sharer. While a line is overflowed, a write raises the trap again so that software can invalidate the sharers that only it knows about.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line is unused with value 0, `req_ready` is 1, and `msg_valid` and `trap` are 0.
- R2: Request opcodes are 0 = read, 1 = write and 2 = write-back. A read of an unused line returns one data message (kind 1) to the requester, carrying the line value and line index. The line then becomes exclusive, clean and owned by the requester. Every accepted read produces at least one message.
- R3: A read by a different node of a line that is exclusive and clean sends a share notice (kind 2) to the owner. After that it sends a data message to the requester, and the line becomes shared with both nodes recorded.
- R4: A read of a line that is exclusive and dirty sends only a forwarded read (kind 3) to the owner, with `msg_req_node` naming the requester. No data message follows.
- R5: A write sends one invalidation (kind 4) to each recorded holder except the writer, in pointer-slot order, and to no other node. The writer then becomes the sole owner of the line, which is exclusive and dirty.
- R6: While messages are pending, `req_ready` is 0. A message that is held back by `msg_ready` = 0 keeps its kind and its node.
- R7: A node that is already recorded for a line is not recorded again. Such a read returns data only, and a later write sends that node a single invalidation.
- R8: A read by a fifth distinct node sets the overflow flag and pulses `trap` for one cycle, with `trap_node` and `trap_line` naming that node and line. The reader still receives data. A write to an overflowed line pulses `trap` again and invalidates only the four recorded pointers, then clears the overflow flag and every pointer except the writer.
- R9: A write-back from the owner of an exclusive line stores `req_data`, clears the dirty flag and returns the line to unused with no pointers. A write-back from any other node changes nothing and sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 write-back |
| req_node | input | NODE_W | Requesting node |
| req_line | input | LINE_W | Line index |
| req_data | input | DW | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 3 | 1 data, 2 share, 3 forward, 4 invalidate |
| msg_node | output | NODE_W | Destination node |
| msg_req_node | output | NODE_W | Node whose request caused the message |
| msg_line | output | LINE_W | Line index |
| msg_data | output | DW | Line value on data messages, else 0 |
| trap | output | 1 | One-cycle software-trap pulse |
| trap_node | output | NODE_W | Node that caused the trap |
| trap_line | output | LINE_W | Line that caused the trap |

## Verification
The hardest state to reach is an overflowed line that then receives a write. Before the write can show its repeated trap and its invalidation list, which leaves out both the writer and the untracked fifth sharer, a single line must first hold four distinct pointers. The stimulus table reaches that state step by step. It first makes the line exclusive and repeats a read by the owner. It then adds a second reader, repeats that reader, and adds two more. A fifth reader trips the overflow, and a write by a node that is already recorded follows. A later forwarded read shows that only the writer's pointer is left.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_WBACK = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      LS_UNUSED = 2'd0,
      LS_SHARED = 2'd1,
      LS_EXCL   = 2'd2
   } lstate_e;

   typedef enum logic [2:0] {
      MK_NONE  = 3'd0,
      MK_DATA  = 3'd1,
      MK_SHARE = 3'd2,
      MK_FWD   = 3'd3,
      MK_INVAL = 3'd4
   } mkind_e;
endpackage

// File: rtl/coh_dir_array.sv
module coh_dir_array
   import coh_dir_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int NPTR   = 4,
   parameter int NODE_W = 4,
   parameter int DW     = 8,
   parameter int LINE_W = $clog2(LINES),
   parameter int CNT_W  = $clog2(NPTR + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LINE_W-1:0]            rd_line,
   output lstate_e                      rd_st,
   output logic                         rd_dirty,
   output logic                         rd_ovf,
   output logic [CNT_W-1:0]             rd_cnt,
   output logic [NPTR-1:0][NODE_W-1:0]  rd_ptrs,
   output logic [DW-1:0]                rd_val,
   input  logic                         we,
   input  lstate_e                      wr_st,
   input  logic                         wr_dirty,
   input  logic                         wr_ovf,
   input  logic [CNT_W-1:0]             wr_cnt,
   input  logic [NPTR-1:0][NODE_W-1:0]  wr_ptrs,
   input  logic [DW-1:0]                wr_val
);
   lstate_e                     st_q    [LINES];
   logic                        dirty_q [LINES];
   logic                        ovf_q   [LINES];
   logic [CNT_W-1:0]            cnt_q   [LINES];
   logic [NPTR-1:0][NODE_W-1:0] ptrs_q  [LINES];
   logic [DW-1:0]               val_q   [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]    <= LS_UNUSED;
            dirty_q[g] <= 1'b0;
            ovf_q[g]   <= 1'b0;
            cnt_q[g]   <= '0;
            ptrs_q[g]  <= '0;
            val_q[g]   <= '0;
         end else if (we && (rd_line == LINE_W'(g))) begin
            st_q[g]    <= wr_st;
            dirty_q[g] <= wr_dirty;
            ovf_q[g]   <= wr_ovf;
            cnt_q[g]   <= wr_cnt;
            ptrs_q[g]  <= wr_ptrs;
            val_q[g]   <= wr_val;
         end
      end
   end

   assign rd_st    = st_q[rd_line];
   assign rd_dirty = dirty_q[rd_line];
   assign rd_ovf   = ovf_q[rd_line];
   assign rd_cnt   = cnt_q[rd_line];
   assign rd_ptrs  = ptrs_q[rd_line];
   assign rd_val   = val_q[rd_line];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (wr_cnt <= CNT_W'(NPTR)));                                   // R8
   AST_EXCL_ONE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_st == LS_EXCL) |-> (wr_cnt == CNT_W'(1)));                // R5
endmodule

// File: rtl/coh_dir_policy.sv
module coh_dir_policy
   import coh_dir_pkg::*;
#(
   parameter int NPTR   = 4,
   parameter int NODE_W = 4,
   parameter int DW     = 8,
   parameter int CNT_W  = $clog2(NPTR + 1)
) (
   input  op_e                          op,
   input  logic [NODE_W-1:0]            node,
   input  logic [DW-1:0]                wdata,
   input  lstate_e                      cur_st,
   input  logic                         cur_dirty,
   input  logic                         cur_ovf,
   input  logic [CNT_W-1:0]             cur_cnt,
   input  logic [NPTR-1:0][NODE_W-1:0]  cur_ptrs,
   input  logic [DW-1:0]                cur_val,
   output logic                         upd,
   output lstate_e                      nxt_st,
   output logic                         nxt_dirty,
   output logic                         nxt_ovf,
   output logic [CNT_W-1:0]             nxt_cnt,
   output logic [NPTR-1:0][NODE_W-1:0]  nxt_ptrs,
   output logic [DW-1:0]                nxt_val,
   output logic [NPTR-1:0]              msk,
   output mkind_e                       pkind,
   output logic                         reply,
   output logic                         trap_req
);
   logic [NPTR-1:0] held;
   logic            dup;

   always_comb begin
      dup = 1'b0;
      for (int i = 0; i < NPTR; i++) begin
         held[i] = (CNT_W'(i) < cur_cnt);
         if (held[i] && cur_ptrs[i] == node) dup = 1'b1;
      end
   end

   always_comb begin
      upd       = 1'b0;
      nxt_st    = cur_st;
      nxt_dirty = cur_dirty;
      nxt_ovf   = cur_ovf;
      nxt_cnt   = cur_cnt;
      nxt_ptrs  = cur_ptrs;
      nxt_val   = cur_val;
      msk       = '0;
      pkind     = MK_NONE;
      reply     = 1'b0;
      trap_req  = 1'b0;
      case (op)
         OP_READ: begin
            if (cur_st == LS_UNUSED) begin
               upd         = 1'b1;
               reply       = 1'b1;
               nxt_st      = LS_EXCL;
               nxt_dirty   = 1'b0;
               nxt_ovf     = 1'b0;
               nxt_cnt     = CNT_W'(1);
               nxt_ptrs    = '0;
               nxt_ptrs[0] = node;
            end else if (cur_st == LS_EXCL && cur_dirty) begin
               msk[0] = 1'b1;
               pkind  = MK_FWD;
            end else begin
               reply = 1'b1;
               if (!dup) begin
                  upd = 1'b1;
                  if (cur_st == LS_EXCL) begin
                     msk[0] = 1'b1;
                     pkind  = MK_SHARE;
                     nxt_st = LS_SHARED;
                  end
                  if (cur_cnt < CNT_W'(NPTR)) begin
                     nxt_cnt = cur_cnt + CNT_W'(1);
                     for (int i = 0; i < NPTR; i++)
                        if (CNT_W'(i) == cur_cnt) nxt_ptrs[i] = node;
                  end else begin
                     nxt_ovf  = 1'b1;
                     trap_req = 1'b1;
                  end
               end
            end
         end
         OP_WRITE: begin
            for (int i = 0; i < NPTR; i++)
               msk[i] = held[i] && (cur_ptrs[i] != node);
            pkind       = MK_INVAL;
            trap_req    = cur_ovf;
            upd         = 1'b1;
            nxt_st      = LS_EXCL;
            nxt_dirty   = 1'b1;
            nxt_ovf     = 1'b0;
            nxt_cnt     = CNT_W'(1);
            nxt_ptrs    = '0;
            nxt_ptrs[0] = node;
         end
         OP_WBACK: begin
            if (cur_st == LS_EXCL && cur_ptrs[0] == node) begin
               upd       = 1'b1;
               nxt_val   = wdata;
               nxt_st    = LS_UNUSED;
               nxt_dirty = 1'b0;
               nxt_ovf   = 1'b0;
               nxt_cnt   = '0;
               nxt_ptrs  = '0;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/coh_dir_msgseq.sv
module coh_dir_msgseq
   import coh_dir_pkg::*;
#(
   parameter int NPTR   = 4,
   parameter int NODE_W = 4,
   parameter int DW     = 8,
   parameter int LINE_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [NPTR-1:0]              ld_msk,
   input  mkind_e                       ld_kind,
   input  logic                         ld_reply,
   input  logic [NPTR-1:0][NODE_W-1:0]  ld_ptrs,
   input  logic [NODE_W-1:0]            ld_src,
   input  logic [LINE_W-1:0]            ld_line,
   input  logic [DW-1:0]                ld_val,
   input  logic                         msg_ready,
   output logic                         busy,
   output logic                         msg_valid,
   output mkind_e                       msg_kind,
   output logic [NODE_W-1:0]            msg_node,
   output logic [NODE_W-1:0]            msg_req_node,
   output logic [LINE_W-1:0]            msg_line,
   output logic [DW-1:0]                msg_data
);
   localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1;

   logic [NPTR-1:0]             msk_q;
   mkind_e                      kind_q;
   logic                        reply_q;
   logic [NPTR-1:0][NODE_W-1:0] ptrs_q;
   logic [NODE_W-1:0]           src_q;
   logic [LINE_W-1:0]           line_q;
   logic [DW-1:0]               val_q;
   logic [SEL_W-1:0]            sel;
   logic                        found;

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = 0; i < NPTR; i++) begin
         if (msk_q[i] && !found) begin
            sel   = SEL_W'(i);
            found = 1'b1;
         end
      end
   end

   assign busy         = (|msk_q) || reply_q;
   assign msg_valid    = busy;
   assign msg_kind     = found ? kind_q : (reply_q ? MK_DATA : MK_NONE);
   assign msg_node     = found ? ptrs_q[sel] : src_q;
   assign msg_req_node = src_q;
   assign msg_line     = line_q;
   assign msg_data     = (!found && reply_q) ? val_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msk_q   <= '0;
         kind_q  <= MK_NONE;
         reply_q <= 1'b0;
         ptrs_q  <= '0;
         src_q   <= '0;
         line_q  <= '0;
         val_q   <= '0;
      end else if (start) begin
         msk_q   <= ld_msk;
         kind_q  <= ld_kind;
         reply_q <= ld_reply;
         ptrs_q  <= ld_ptrs;
         src_q   <= ld_src;
         line_q  <= ld_line;
         val_q   <= ld_val;
      end else if (msg_valid && msg_ready) begin
         if (found) msk_q[sel] <= 1'b0;
         else       reply_q    <= 1'b0;
      end
   end

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_node))); // R6
   AST_INVAL_SKIPS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == MK_INVAL) |-> (msg_node != msg_req_node));                  // R5
   AST_DATA_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_kind == MK_DATA) |=> !msg_valid);                      // R2
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
   import coh_dir_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int NPTR   = 4,
   parameter int NODE_W = 4,
   parameter int DW     = 8,
   parameter int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [NODE_W-1:0] req_node,
   input  logic [LINE_W-1:0] req_line,
   input  logic [DW-1:0]     req_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [2:0]        msg_kind,
   output logic [NODE_W-1:0] msg_node,
   output logic [NODE_W-1:0] msg_req_node,
   output logic [LINE_W-1:0] msg_line,
   output logic [DW-1:0]     msg_data,
   output logic              trap,
   output logic [NODE_W-1:0] trap_node,
   output logic [LINE_W-1:0] trap_line
);
   localparam int CNT_W = $clog2(NPTR + 1);

   if (LINES < 2 || (1 << LINE_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two matching LINE_W");
   end
   if (NPTR < 2 || NPTR > (1 << NODE_W)) begin : g_bad_ptrs
      $error("NPTR must lie between 2 and the node count");
   end

   lstate_e                     cur_st, nxt_st;
   logic                        cur_dirty, cur_ovf, nxt_dirty, nxt_ovf;
   logic [CNT_W-1:0]            cur_cnt, nxt_cnt;
   logic [NPTR-1:0][NODE_W-1:0] cur_ptrs, nxt_ptrs;
   logic [DW-1:0]               cur_val, nxt_val;
   logic                        upd, reply, trap_req, busy, accept;
   logic [NPTR-1:0]             msk;
   mkind_e                      pkind, kind_out;

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;
   assign msg_kind  = kind_out;

   coh_dir_array #(.LINES(LINES), .NPTR(NPTR), .NODE_W(NODE_W), .DW(DW),
                   .LINE_W(LINE_W), .CNT_W(CNT_W)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_line(req_line),
      .rd_st(cur_st), .rd_dirty(cur_dirty), .rd_ovf(cur_ovf),
      .rd_cnt(cur_cnt), .rd_ptrs(cur_ptrs), .rd_val(cur_val),
      .we(accept && upd), .wr_st(nxt_st), .wr_dirty(nxt_dirty),
      .wr_ovf(nxt_ovf), .wr_cnt(nxt_cnt), .wr_ptrs(nxt_ptrs), .wr_val(nxt_val)
   );

   coh_dir_policy #(.NPTR(NPTR), .NODE_W(NODE_W), .DW(DW), .CNT_W(CNT_W)) u_policy (
      .op(op_e'(req_op)), .node(req_node), .wdata(req_data),
      .cur_st(cur_st), .cur_dirty(cur_dirty), .cur_ovf(cur_ovf),
      .cur_cnt(cur_cnt), .cur_ptrs(cur_ptrs), .cur_val(cur_val),
      .upd(upd), .nxt_st(nxt_st), .nxt_dirty(nxt_dirty), .nxt_ovf(nxt_ovf),
      .nxt_cnt(nxt_cnt), .nxt_ptrs(nxt_ptrs), .nxt_val(nxt_val),
      .msk(msk), .pkind(pkind), .reply(reply), .trap_req(trap_req)
   );

   coh_dir_msgseq #(.NPTR(NPTR), .NODE_W(NODE_W), .DW(DW), .LINE_W(LINE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept && ((|msk) || reply)),
      .ld_msk(msk), .ld_kind(pkind), .ld_reply(reply), .ld_ptrs(cur_ptrs),
      .ld_src(req_node), .ld_line(req_line), .ld_val(cur_val),
      .msg_ready(msg_ready), .busy(busy), .msg_valid(msg_valid),
      .msg_kind(kind_out), .msg_node(msg_node), .msg_req_node(msg_req_node),
      .msg_line(msg_line), .msg_data(msg_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap      <= 1'b0;
         trap_node <= '0;
         trap_line <= '0;
      end else begin
         trap <= accept && trap_req;
         if (accept) begin
            trap_node <= req_node;
            trap_line <= req_line;
         end
      end
   end

   AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> !trap);                                                    // R8
   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_op == 2'd0) |=> (msg_valid && !req_ready));          // R2
endmodule

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2;
   localparam logic [2:0] KD = 3'd1, KS = 3'd2, KF = 3'd3, KI = 3'd4;

   typedef struct packed {
      logic [1:0]      op;
      logic [3:0]      node;
      logic [3:0]      line;
      logic [7:0]      data;
      logic            trp;
      logic [2:0]      n;
      logic [7:0]      rdata;
      logic [0:4][6:0] m;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{WB, 4'd5, 4'd3, 8'hAA, 1'b0, 3'd0, 8'h00, '{7'd0, 7'd0, 7'd0, 7'd0, 7'd0}},                   // R9 non-owner
      '{RD, 4'd5, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd5}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R2
      '{RD, 4'd5, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd5}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R7
      '{RD, 4'd6, 4'd3, 8'h00, 1'b0, 3'd2, 8'h00, '{{KS,4'd5}, {KD,4'd6}, 7'd0, 7'd0, 7'd0}},         // R3
      '{RD, 4'd6, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd6}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R7
      '{RD, 4'd7, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd7}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R3
      '{RD, 4'd8, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd8}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R3
      '{RD, 4'd9, 4'd3, 8'h00, 1'b1, 3'd1, 8'h00, '{{KD,4'd9}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R8
      '{WR, 4'd6, 4'd3, 8'h00, 1'b1, 3'd3, 8'h00, '{{KI,4'd5}, {KI,4'd7}, {KI,4'd8}, 7'd0, 7'd0}},    // R5 R8
      '{RD, 4'd2, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KF,4'd6}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R4 R8
      '{WB, 4'd2, 4'd3, 8'h55, 1'b0, 3'd0, 8'h00, '{7'd0, 7'd0, 7'd0, 7'd0, 7'd0}},                   // R9 non-owner
      '{WB, 4'd6, 4'd3, 8'h3C, 1'b0, 3'd0, 8'h00, '{7'd0, 7'd0, 7'd0, 7'd0, 7'd0}},                   // R9 owner
      '{RD, 4'd1, 4'd3, 8'h00, 1'b0, 3'd1, 8'h3C, '{{KD,4'd1}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R9 R2
      '{WR, 4'd4, 4'd3, 8'h00, 1'b0, 3'd1, 8'h00, '{{KI,4'd1}, 7'd0, 7'd0, 7'd0, 7'd0}},              // R5
      '{RD, 4'd0, 4'd9, 8'h00, 1'b0, 3'd1, 8'h00, '{{KD,4'd0}, 7'd0, 7'd0, 7'd0, 7'd0}}               // R2
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       req_valid = 1'b0, msg_ready = 1'b1;
   logic [1:0] req_op = '0;
   logic [3:0] req_node = '0, req_line = '0;
   logic [7:0] req_data = '0;
   logic       req_ready, msg_valid, trap;
   logic [2:0] msg_kind;
   logic [3:0] msg_node, msg_req_node, msg_line, trap_node, trap_line;
   logic [7:0] msg_data;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   coh_dir_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_node(req_node), .req_line(req_line), .req_data(req_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_node(msg_node), .msg_req_node(msg_req_node), .msg_line(msg_line),
      .msg_data(msg_data), .trap(trap), .trap_node(trap_node), .trap_line(trap_line)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [3:0] node,
                       input logic [3:0] line, input logic [7:0] data);
      @(negedge clk);
      chk(req_ready, "R6", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_op = op; req_node = node; req_line = line; req_data = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
      chk(msg_valid == 1'b0, "R1", "reset msg_valid", int'(msg_valid), 0);
      chk(trap == 1'b0,      "R1", "reset trap", int'(trap), 0);

      for (int v = 0; v < NV; v++) begin
         int cnt;
         send(VEC[v].op, VEC[v].node, VEC[v].line, VEC[v].data);
         chk(trap == VEC[v].trp, "R8", $sformatf("vec %0d trap", v), int'(trap), int'(VEC[v].trp));
         if (VEC[v].trp)
            chk(trap_node == VEC[v].node && trap_line == VEC[v].line, "R8",
                $sformatf("vec %0d trap node", v), int'(trap_node), int'(VEC[v].node));
         if (msg_valid)
            chk(!req_ready, "R6", $sformatf("vec %0d busy", v), int'(req_ready), 0);
         cnt = 0;
         while (msg_valid && cnt < 6) begin
            if (cnt < 5) begin
               chk({msg_kind, msg_node} == VEC[v].m[cnt], "R5",
                   $sformatf("vec %0d msg %0d kind/node", v, cnt),
                   int'({msg_kind, msg_node}), int'(VEC[v].m[cnt]));
               chk(msg_line == VEC[v].line, "R2", $sformatf("vec %0d line", v),
                   int'(msg_line), int'(VEC[v].line));
               if (msg_kind == KD)
                  chk(msg_data == VEC[v].rdata, "R9", $sformatf("vec %0d data", v),
                      int'(msg_data), int'(VEC[v].rdata));
            end
            cnt++;
            @(negedge clk);
         end
         chk(cnt == int'(VEC[v].n), "R5", $sformatf("vec %0d message count", v),
             cnt, int'(VEC[v].n));
      end

      // R6: back-pressure on a read of line 9, owned clean by node 0
      msg_ready = 1'b0;
      send(RD, 4'd1, 4'd9, 8'h00);
      chk(msg_valid && msg_kind == KS && msg_node == 4'd0, "R3", "share to owner",
          int'({msg_kind, msg_node}), int'({KS, 4'd0}));
      repeat (2) begin
         @(negedge clk);
         chk(msg_valid && msg_kind == KS && msg_node == 4'd0, "R6", "held under stall",
             int'({msg_kind, msg_node}), int'({KS, 4'd0}));
         chk(!req_ready, "R6", "not ready under stall", int'(req_ready), 0);
      end
      msg_ready = 1'b1;
      @(negedge clk);
      chk(msg_valid && msg_kind == KD && msg_node == 4'd1, "R3", "data after share",
          int'({msg_kind, msg_node}), int'({KD, 4'd1}));
      @(negedge clk);
      chk(!msg_valid && req_ready, "R6", "idle after sequence", int'(msg_valid), 0);

      // R5: write by node 2 invalidates nodes 0 and 1
      send(WR, 4'd2, 4'd9, 8'h00);
      chk(msg_kind == KI && msg_node == 4'd0, "R5", "first invalidation",
          int'({msg_kind, msg_node}), int'({KI, 4'd0}));
      @(negedge clk);
      chk(msg_kind == KI && msg_node == 4'd1, "R5", "second invalidation",
          int'({msg_kind, msg_node}), int'({KI, 4'd1}));
      @(negedge clk);
      chk(!msg_valid, "R5", "no third invalidation", int'(msg_valid), 0);

      // R4: read of dirty line is forwarded with the requester named
      send(RD, 4'd3, 4'd9, 8'h00);
      chk(msg_kind == KF && msg_node == 4'd2, "R4", "forward to owner",
          int'({msg_kind, msg_node}), int'({KF, 4'd2}));
      chk(msg_req_node == 4'd3, "R4", "forward names requester", int'(msg_req_node), 3);
      @(negedge clk);
      chk(!msg_valid, "R4", "no data after forward", int'(msg_valid), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule